// File: doc/BRIEF.md
# Operand Effective Address Unit

This block turns a decoded operand specifier into the location where the operand lives, for a 16-bit machine with sixteen general registers and a word-addressed memory of 2^15 words. The issuing logic supplies a three-bit mode code, an instruction-class code, a register number, a 16-bit displacement and the current program counter, and pulses `start`. The unit reads the register file combinationally in that same cycle. Two modes dereference a pointer held in memory, and for these it runs one read over a request/valid memory port.

The result is either a register selector (register direct mode) or a 15-bit memory address. It comes with a one-cycle `done` pulse and stays on the outputs until the next operation finishes. Any mode that the instruction class forbids, and any unsigned-only displacement that has bit 15 set, raises `illegal` and produces no memory traffic. All address arithmetic wraps modulo 2^15.

Top module: `operand_addr_unit`

## Requirements
- R1: Mode 0 (register direct) gives `isReg`=1 and `regSel`=`regNum`. For every mode that needs no memory read, `done` is high for exactly the one cycle after the `start` cycle.
- R2: Mode 1 (memory direct) gives `addr` = `disp[14:0]`. A `disp` with bit 15 set is illegal in this mode.
- R3: Mode 2 (indexed) gives `addr` = (register[14:0] + `disp[14:0]`) mod 2^15.
- R4: Mode 3 (immediate) gives `addr` = (`pc` − 1) mod 2^15, so `pc`=0 gives 0x7FFF.
- R5: Mode 7 (PC relative) gives `addr` = (`pc` + `disp[14:0]`) mod 2^15.
- R6: Mode 4 (register indirect) gives `addr` = register[14:0] and issues no memory request.
- R7: Mode 5 (memory indirect) issues one read at `disp[14:0]` and returns `addr` = `memRspData[14:0]`. A `disp` with bit 15 set is illegal in this mode.
- R8: Mode 6 (indexed indirect) issues one read at (register[14:0] + `disp[14:0]`) mod 2^15 and returns `addr` = `memRspData[14:0]`.
- R9: Class 0 (general) allows every mode. Class 1 (jump/subroutine/block move) rejects modes 0 and 3. Class 2 (store/floating point) rejects mode 3. Class 3 (load address) rejects mode 0. A rejected operation ends with `illegal`=1 and `isReg`=0.
- R10: An illegal operation never raises `memReqValid`, and its `done` comes one cycle after `start`.
- R11: `memReqValid` stays high with a stable `memReqAddr` until `memRspValid` is seen. `done` follows in the next cycle, and the request drops in that same cycle.
- R12: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; honoured only while `busy` is low |
| mode | input | 3 | Addressing mode code (see R1–R8) |
| opClass | input | 2 | Instruction class code (see R9) |
| regNum | input | 4 | Register number of the operand |
| disp | input | 16 | Displacement word |
| pc | input | 15 | Current program counter |
| regRdIdx | output | 4 | Register file read index |
| regRdData | input | 16 | Register file read data, combinational |
| memReqValid | output | 1 | Memory read request |
| memReqAddr | output | 15 | Memory read address |
| memRspValid | input | 1 | Memory read data valid |
| memRspData | input | 16 | Memory read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| isReg | output | 1 | Result is a register selector |
| regSel | output | 4 | Register selector result |
| addr | output | 15 | Memory address result |
| illegal | output | 1 | Mode not allowed or displacement out of range |

## Verification
The bench aims at the wrap points. Immediate mode with `pc`=0 checks that a design which fails to wrap would not return 0x7FFF. Indexed sums that overflow 15 bits check that a wrong design would not leak bit 15 or carry into it. Memory-direct and memory-indirect displacements with bit 15 set check that a design which skips the range test would return a wrapped address instead of flagging an error. Every class and mode pairing is driven, so a wrong legality table would show up as a missing error flag or as a spurious memory request. Random memory latencies, together with `start` pulses injected during a pending read, would expose a request that drops early, an address that moves, or a second operation that overwrites the first.

// File: rtl/oau_pkg.sv
package oau_pkg;
  typedef enum logic [2:0] {
    MODE_REG   = 3'd0,
    MODE_MEM   = 3'd1,
    MODE_IDX   = 3'd2,
    MODE_IMM   = 3'd3,
    MODE_RIND  = 3'd4,
    MODE_MIND  = 3'd5,
    MODE_XIND  = 3'd6,
    MODE_PCREL = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    CLS_GEN   = 2'd0,
    CLS_XFER  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_LDA   = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FIN  = 2'd2
  } state_e;

  typedef struct packed {
    logic capture;
    logic loadRsp;
  } strobe_t;

  function automatic logic modeAllowed(cls_e cls, mode_e m);
    case (cls)
      CLS_XFER:  return !(m == MODE_REG || m == MODE_IMM);
      CLS_STORE: return m != MODE_IMM;
      CLS_LDA:   return m != MODE_REG;
      default:   return 1'b1;
    endcase
  endfunction

  function automatic logic dispUnsignedOnly(mode_e m);
    return (m == MODE_MEM) || (m == MODE_MIND);
  endfunction

  function automatic logic needsMemRead(mode_e m);
    return (m == MODE_MIND) || (m == MODE_XIND);
  endfunction
endpackage

// File: rtl/oau_datapath.sv
module oau_datapath
  import oau_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  logic [2:0]        modeIn,
  input  logic [1:0]        clsIn,
  input  logic [REG_W-1:0]  regNum,
  input  logic [DATA_W-1:0] disp,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] memRspData,
  output logic              needsMem,
  output logic              illegalNow,
  output logic [ADDR_W-1:0] addr,
  output logic              isReg,
  output logic [REG_W-1:0]  regSel,
  output logic              illegal
);
  mode_e modeCur;
  cls_e  clsCur;
  logic [ADDR_W-1:0] dispLow;
  logic [ADDR_W-1:0] regLow;
  logic [ADDR_W-1:0] eaNext;

  logic [ADDR_W-1:0] addrQ;
  logic              isRegQ;
  logic [REG_W-1:0]  regSelQ;
  logic              illegalQ;

  assign modeCur = mode_e'(modeIn);
  assign clsCur  = cls_e'(clsIn);
  assign dispLow = disp[ADDR_W-1:0];
  assign regLow  = regRdData[ADDR_W-1:0];

  always_comb begin
    case (modeCur)
      MODE_MEM, MODE_MIND: eaNext = dispLow;
      MODE_IDX, MODE_XIND: eaNext = regLow + dispLow;
      MODE_IMM:            eaNext = pc - ADDR_W'(1);
      MODE_RIND:           eaNext = regLow;
      MODE_PCREL:          eaNext = pc + dispLow;
      default:             eaNext = '0;
    endcase
  end

  assign needsMem   = needsMemRead(modeCur);
  assign illegalNow = !modeAllowed(clsCur, modeCur) ||
                      (dispUnsignedOnly(modeCur) && disp[DATA_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ    <= '0;
      isRegQ   <= 1'b0;
      regSelQ  <= '0;
      illegalQ <= 1'b0;
    end else if (strobe.capture) begin
      addrQ    <= illegalNow ? '0 : eaNext;
      isRegQ   <= !illegalNow && (modeCur == MODE_REG);
      regSelQ  <= regNum;
      illegalQ <= illegalNow;
    end else if (strobe.loadRsp) begin
      addrQ    <= memRspData[ADDR_W-1:0];
    end
  end

  assign addr    = addrQ;
  assign isReg   = isRegQ;
  assign regSel  = regSelQ;
  assign illegal = illegalQ;
endmodule

// File: rtl/oau_ctrl.sv
module oau_ctrl
  import oau_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    needsMem,
  input  logic    illegalNow,
  input  logic    memRspValid,
  output strobe_t strobe,
  output logic    memReqValid,
  output logic    busy,
  output logic    done
);
  state_e state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.capture = 1'b0;
    strobe.loadRsp = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        strobe.capture = 1'b1;
        stateNext = (needsMem && !illegalNow) ? ST_WAIT : ST_FIN;
      end
      ST_WAIT: if (memRspValid) begin
        strobe.loadRsp = 1'b1;
        stateNext = ST_FIN;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign memReqValid = (state == ST_WAIT);
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FIN);
endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import oau_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [1:0]        opClass,
  input  logic [REG_W-1:0]  regNum,
  input  logic [DATA_W-1:0] disp,
  input  logic [ADDR_W-1:0] pc,
  output logic [REG_W-1:0]  regRdIdx,
  input  logic [DATA_W-1:0] regRdData,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              busy,
  output logic              done,
  output logic              isReg,
  output logic [REG_W-1:0]  regSel,
  output logic [ADDR_W-1:0] addr,
  output logic              illegal
);
  strobe_t strobe;
  logic    needsMem;
  logic    illegalNow;

  assign regRdIdx   = regNum;
  assign memReqAddr = addr;

  oau_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .needsMem    (needsMem),
    .illegalNow  (illegalNow),
    .memRspValid (memRspValid),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .busy        (busy),
    .done        (done)
  );

  oau_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .modeIn     (mode),
    .clsIn      (opClass),
    .regNum     (regNum),
    .disp       (disp),
    .pc         (pc),
    .regRdData  (regRdData),
    .memRspData (memRspData),
    .needsMem   (needsMem),
    .illegalNow (illegalNow),
    .addr       (addr),
    .isReg      (isReg),
    .regSel     (regSel),
    .illegal    (illegal)
  );
endmodule

// File: rtl/oau_checker.sv
module oau_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              illegal,
  input logic              isReg
);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_req_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> !illegal);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memRspValid) |=> (memReqValid && $stable(memReqAddr)));

  assert_done_after_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && memRspValid) |=> (done && !memReqValid));

  assert_busy_after_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_illegal_not_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> !isReg);

  assert_req_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memReqValid) |-> $past(start && !busy));
endmodule

bind operand_addr_unit oau_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .illegal     (illegal),
  .isReg       (isReg)
);

// File: tb/operand_addr_unit_tb.sv
`timescale 1ns/1ps
module operand_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  opClass = '0;
  logic [3:0]  regNum = '0;
  logic [15:0] disp = '0;
  logic [14:0] pc = '0;
  logic [3:0]  regRdIdx;
  logic [15:0] regRdData;
  logic        memReqValid;
  logic [14:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [15:0] memRspData = '0;
  logic        busy, done, isReg, illegal;
  logic [3:0]  regSel;
  logic [14:0] addr;

  logic [15:0] regs [16];
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;
  assign regRdData = regs[regRdIdx];

  operand_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opClass(opClass),
    .regNum(regNum), .disp(disp), .pc(pc), .regRdIdx(regRdIdx),
    .regRdData(regRdData), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .busy(busy),
    .done(done), .isReg(isReg), .regSel(regSel), .addr(addr), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string modeTag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R5";
    endcase
  endfunction

  function automatic logic expLegal(input logic [2:0] m, input logic [1:0] c, input logic [15:0] d);
    logic ok;
    case (c)
      2'd1: ok = !(m == 3'd0 || m == 3'd3);
      2'd2: ok = (m != 3'd3);
      2'd3: ok = (m != 3'd0);
      default: ok = 1'b1;
    endcase
    if ((m == 3'd1 || m == 3'd5) && d[15]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [14:0] expAddr(input logic [2:0] m, input logic [15:0] r,
                                          input logic [15:0] d, input logic [14:0] p);
    case (m)
      3'd1, 3'd5: return d[14:0];
      3'd2, 3'd6: return 15'(r[14:0] + d[14:0]);
      3'd3:       return 15'(p - 15'd1);
      3'd4:       return r[14:0];
      3'd7:       return 15'(p + d[14:0]);
      default:    return 15'd0;
    endcase
  endfunction

  task automatic doOp(input logic [2:0] m, input logic [1:0] c, input logic [3:0] r,
                      input logic [15:0] d, input logic [14:0] p, input int lat,
                      input logic [15:0] rsp, input bit poke);
    logic legal;
    logic viaMem;
    logic [14:0] ea;
    string tag;
    legal  = expLegal(m, c, d);
    viaMem = legal && (m == 3'd5 || m == 3'd6);
    ea     = expAddr(m, regs[r], d, p);
    tag    = legal ? modeTag(m) : "R9";
    @(negedge clk);
    mode = m; opClass = c; regNum = r; disp = d; pc = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 busy", busy, 1);
    if (!viaMem) begin
      chk({tag, " done"}, done, 1);
      chk(legal ? {tag, " no req"} : "R10 no req", memReqValid, 0);
      chk({tag, " illegal"}, illegal, !legal);
      if (!legal) chk("R9 isReg", isReg, 0);
      else if (m == 3'd0) chk("R1 regSel", {isReg, regSel}, {1'b1, r});
      else chk({tag, " addr"}, {isReg, addr}, {1'b0, ea});
    end else begin
      chk({tag, " req"}, {memReqValid, memReqAddr}, {1'b1, ea});
      if (poke) begin
        mode = 3'd0; opClass = 2'd0; regNum = ~r; disp = ~d; start = 1'b1;
      end
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        start = 1'b0;
        chk("R11 hold", {done, memReqValid, memReqAddr}, {2'b01, ea});
      end
      start = 1'b0;
      memRspValid = 1'b1; memRspData = rsp;
      @(negedge clk);
      memRspValid = 1'b0; memRspData = ~rsp;
      chk("R11 done", {done, memReqValid}, 2'b10);
      chk({tag, poke ? " R12 poke addr" : " addr"}, {illegal, isReg, addr}, {2'b00, rsp[14:0]});
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) regs[i] = 16'($urandom());
    repeat (3) @(negedge clk);
    chk("R12 reset busy", {busy, done, memReqValid, illegal}, 0);
    rst_n = 1'b1;
    regs[3] = 16'h7FF0; regs[5] = 16'h8123; regs[9] = 16'h0040;
    doOp(3'd0, 2'd0, 4'd7, 16'h0000, 15'h0100, 0, 0, 0);
    doOp(3'd1, 2'd0, 4'd0, 16'h7FFF, 15'h0000, 0, 0, 0);
    doOp(3'd1, 2'd0, 4'd0, 16'h8000, 15'h0000, 0, 0, 0);
    doOp(3'd2, 2'd0, 4'd3, 16'h0020, 15'h0000, 0, 0, 0);
    doOp(3'd2, 2'd0, 4'd9, 16'hFFF0, 15'h0000, 0, 0, 0);
    doOp(3'd3, 2'd0, 4'd0, 16'h0000, 15'h0000, 0, 0, 0);
    doOp(3'd3, 2'd3, 4'd0, 16'h0000, 15'h1234, 0, 0, 0);
    doOp(3'd7, 2'd0, 4'd0, 16'hFFF6, 15'h0005, 0, 0, 0);
    doOp(3'd4, 2'd1, 4'd5, 16'h0000, 15'h0000, 0, 0, 0);
    doOp(3'd5, 2'd1, 4'd0, 16'h0ABC, 15'h0000, 3, 16'hF00D, 0);
    doOp(3'd5, 2'd0, 4'd0, 16'h8ABC, 15'h0000, 3, 16'hF00D, 0);
    doOp(3'd6, 2'd2, 4'd3, 16'h0020, 15'h0000, 0, 16'h1357, 1);
    doOp(3'd0, 2'd1, 4'd2, 16'h0000, 15'h0000, 0, 0, 0);
    doOp(3'd3, 2'd1, 4'd2, 16'h0000, 15'h0010, 0, 0, 0);
    doOp(3'd3, 2'd2, 4'd2, 16'h0000, 15'h0010, 0, 0, 0);
    doOp(3'd0, 2'd3, 4'd2, 16'h0000, 15'h0010, 0, 0, 0);
    doOp(3'd6, 2'd1, 4'd0, 16'h0000, 15'h0000, 2, 16'h0000, 1);
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) for (int i = 0; i < 16; i++) regs[i] = 16'($urandom());
      doOp(3'($urandom()), 2'($urandom()), 4'($urandom()), 16'($urandom()),
           15'($urandom()), int'($urandom() % 4), 16'($urandom()), 1'($urandom()));
    end
    repeat (2) @(negedge clk);
    chk("R12 idle", {busy, done, memReqValid}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule